// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software or a
neighbouring block pushes characters into a sixteen-entry byte queue with a
one-cycle write strobe. The engine takes characters from the head of the queue
and shifts them out on a single serial line. Its timing comes from a one-cycle
enable that pulses at sixteen times the baud rate, so the system clock may run
at any rate above that.

The character format is chosen at run time. Each character may carry five to
eight data bits. An optional parity bit can be odd, even, or forced to one or
zero. The stop interval is one bit, or an extended length that the engine sizes
in half-bit steps from the word length and the parity setting. The format is
captured when a character starts, so a change made during a frame affects only
the next frame. A clear-to-send input can hold back new characters, and a break
request pulls the line low. A queue-clear input drops everything still waiting
in the queue.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, and whenever no frame is in progress and no break is requested, `txd` is high, `empty` is 1, `full` is 0 and `count` is 0 (for the reset state).
- R2: A frame begins with one low start bit. It is followed by the data bits, least-significant first. The bit count is `word_len`+5, so code 0 gives 5 bits and code 3 gives 8 bits. Data bits above the word length are not sent.
- R3: `parity_mode` selects the parity bit. 000, 010, 100 and 110 send no parity bit. 001 sends odd parity, 011 even parity, 101 a constant 1 and 111 a constant 0. The parity bit follows the last data bit and covers only the bits that are sent.
- R4: Every bit lasts 16 ticks of `tick16`. With `stop_ext`=0 the stop interval is 2 half-bits. With `stop_ext`=1 it is 4 half-bits, with two exceptions: 3 half-bits for 5 data bits without parity, and 2 half-bits for 8 data bits with parity. The stop level is high. A frame lasts 16*(1+bits+parity) + 8*halves ticks.
- R5: The queue holds 16 characters. `count` gives its occupancy, and `full` and `empty` flag 16 and 0. A write while `full` is 1 is dropped and leaves `count` unchanged.
- R6: With `q_clear` high, `count` is 0 one clock later. `q_clear` wins over a write in the same cycle.
- R7: A new frame starts only while `cts` is 1 or `flow_en` is 0. A frame that has started runs to its end even if `cts` falls during it.
- R8: While `brk` is 1, `txd` is low from the next clock onward and no new frame starts. Queued characters stay queued.
- R9: When another character is waiting and may start, it begins on the tick right after the last tick of the previous frame, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| wr_en | input | 1 | Write strobe that pushes `wr_data` into the queue |
| wr_data | input | 8 | Character to queue |
| q_clear | input | 1 | Empties the queue |
| word_len | input | 2 | Data bit count minus 5 |
| parity_mode | input | 3 | Parity selection (see R3) |
| stop_ext | input | 1 | Requests the extended stop interval |
| brk | input | 1 | Break request: line held low |
| cts | input | 1 | Clear-to-send, active high |
| flow_en | input | 1 | 1 = `cts` gates new frames, 0 = `cts` ignored |
| txd | output | 1 | Serial line, idle high |
| full | output | 1 | Queue holds 16 characters |
| empty | output | 1 | Queue holds no character |
| count | output | 5 | Queue occupancy |

## Verification
The assertions check these properties on every cycle:
- The break level and the idle-high line.
- That a frame begins only when clear-to-send or the flow-control bypass allowed it.
- That the tick counter stays inside the captured frame length.
- That the queue never pops while empty, never overflows, ignores writes while full, and empties after a clear.

Only the bench's scenarios show the bit contents and their order, the value of each parity mode, and the frame length that follows from the stop-interval rules. The same applies to the gapless restart between frames, to a frame completing after clear-to-send drops, and to characters held back by a break.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // ticks of the 16x enable per bit, and as a shift
  localparam int TICKS_PER_BIT = 16;
  localparam int BIT_SHIFT     = $clog2(TICKS_PER_BIT);
  localparam int HALF_TICKS    = TICKS_PER_BIT / 2;
  localparam int DATA_W        = 8;
  localparam int NBITS_W       = 4;
  // longest frame: start + 8 data + parity + 2 stop bits
  localparam int MAX_FRAME     = TICKS_PER_BIT * (1 + DATA_W + 1 + 2);
  localparam int FLEN_W        = $clog2(MAX_FRAME + 1);

  typedef logic [FLEN_W-1:0] flen_t;

  // parity bit value; mode[2:1]: 00 odd, 01 even, 10 one, 11 zero
  function automatic logic parity_value(input logic [2:1] sel,
                                        input logic [DATA_W-1:0] bits);
    logic x;
    x = ^bits;
    case (sel)
      2'b00:   parity_value = ~x;
      2'b01:   parity_value = x;
      2'b10:   parity_value = 1'b1;
      default: parity_value = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, wptr_d, rptr, rptr_d;
  logic [CW-1:0]    count_d;
  logic             wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr & ~full & ~clr;
  assign rd_ok = rd & ~empty & ~clr;
  assign rdata = mem[rptr];

  always_comb begin
    wptr_d  = wptr;
    rptr_d  = rptr;
    count_d = count;
    if (clr) begin
      wptr_d  = '0;
      rptr_d  = '0;
      count_d = '0;
    end else begin
      if (wr_ok) wptr_d = wptr + PW'(1);
      if (rd_ok) rptr_d = rptr + PW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   count_d = count + CW'(1);
        2'b01:   count_d = count - CW'(1);
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_d;
      rptr  <= rptr_d;
      count <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_ok && (wptr == PW'(i))) mem[i] <= wdata;
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_drop_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd && !clr) |=> (count == CW'(DEPTH)));
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !empty);
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
  import uart_tx_pkg::*;
(
  input  logic [1:0]         word_len,
  input  logic [2:0]         parity_mode,
  input  logic               stop_ext,
  output logic [NBITS_W-1:0] nbits,
  output logic               par_en,
  output flen_t              flen
);
  logic [2:0] halves;

  assign nbits  = NBITS_W'(word_len) + NBITS_W'(5);
  assign par_en = parity_mode[0];

  always_comb begin
    if (!stop_ext)
      halves = 3'd2;
    else if (nbits == NBITS_W'(8) && par_en)
      halves = 3'd2;
    else if (nbits == NBITS_W'(5) && !par_en)
      halves = 3'd3;
    else
      halves = 3'd4;
  end

  assign flen = flen_t'(TICKS_PER_BIT) * (flen_t'(1) + flen_t'(nbits) + flen_t'(par_en))
              + flen_t'(HALF_TICKS) * flen_t'(halves);
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               avail,
  input  logic               allow,
  input  logic               brk,
  input  logic [DATA_W-1:0]  din,
  input  logic [NBITS_W-1:0] nbits,
  input  logic               par_en,
  input  logic [2:0]         parity_mode,
  input  flen_t              flen,
  output logic               pop,
  output logic               txd
);
  logic               busy, busy_d;
  flen_t              tcnt, tcnt_d, flen_q;
  logic [DATA_W-1:0]  data_q, masked;
  logic [NBITS_W-1:0] nbits_q;
  logic               par_en_q, par_q, par_new;
  logic               last, line_d, dbit;
  logic [3:0]         idx;

  assign last    = busy && (tcnt == flen_q - flen_t'(1));
  assign pop     = tick && avail && allow && (!busy || last);
  assign masked  = din & ~(DATA_W'({DATA_W{1'b1}}) << nbits);
  assign par_new = parity_value(parity_mode[2:1], masked);
  assign idx     = 4'(tcnt >> BIT_SHIFT);

  // next frame state
  always_comb begin
    busy_d = busy;
    tcnt_d = tcnt;
    if (pop) begin
      busy_d = 1'b1;
      tcnt_d = '0;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy) begin
      tcnt_d = tcnt + flen_t'(1);
    end
  end

  // line level for the current tick position
  always_comb begin
    dbit = 1'b1;
    for (int k = 0; k < DATA_W; k++) begin
      if (idx == 4'(k + 1)) dbit = data_q[k];
    end
    if (brk)
      line_d = 1'b0;
    else if (!busy)
      line_d = 1'b1;
    else if (idx == 4'd0)
      line_d = 1'b0;
    else if (idx <= nbits_q)
      line_d = dbit;
    else if (par_en_q && idx == nbits_q + 4'd1)
      line_d = par_q;
    else
      line_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tcnt     <= '0;
      flen_q   <= '0;
      data_q   <= '0;
      nbits_q  <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
      txd      <= 1'b1;
    end else begin
      txd <= line_d;
      if (tick) begin
        busy <= busy_d;
        tcnt <= tcnt_d;
      end
      if (pop) begin
        data_q   <= masked;
        nbits_q  <= nbits;
        par_en_q <= par_en;
        par_q    <= par_new;
        flen_q   <= flen;
      end
    end
  end

  assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |=> txd);
  assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(allow));
  assert_tick_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt < flen_q));
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              q_clear,
  input  logic [1:0]        word_len,
  input  logic [2:0]        parity_mode,
  input  logic              stop_ext,
  input  logic              brk,
  input  logic              cts,
  input  logic              flow_en,
  output logic              txd,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count
);
  logic               rst_meta, rst_sync;
  logic [DATA_W-1:0]  head;
  logic               pop, allow;
  logic [NBITS_W-1:0] nbits;
  logic               par_en;
  flen_t              flen;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign allow = (cts | ~flow_en) & ~brk;

  uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync),
    .clr   (q_clear),
    .wr    (wr_en),
    .wdata (wr_data),
    .rd    (pop),
    .rdata (head),
    .full  (full),
    .empty (empty),
    .count (count)
  );

  uart_tx_fmt u_fmt (
    .word_len    (word_len),
    .parity_mode (parity_mode),
    .stop_ext    (stop_ext),
    .nbits       (nbits),
    .par_en      (par_en),
    .flen        (flen)
  );

  uart_tx_serializer u_ser (
    .clk         (clk),
    .rst_n       (rst_sync),
    .tick        (tick16),
    .avail       (~empty),
    .allow       (allow),
    .brk         (brk),
    .din         (head),
    .nbits       (nbits),
    .par_en      (par_en),
    .parity_mode (parity_mode),
    .flen        (flen),
    .pop         (pop),
    .txd         (txd)
  );
endmodule

// File: tb/uart_tx_engine_tb.sv
module uart_tx_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       q_clear = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic [2:0] parity_mode = 3'b000;
  logic       stop_ext = 1'b0;
  logic       brk = 1'b0;
  logic       cts = 1'b1;
  logic       flow_en = 1'b0;
  logic       txd, full, empty;
  logic [4:0] count;

  int total = 0;
  int fails = 0;
  int tick_cnt = 0;
  int cycles = 0;
  logic [1:0] ph = 2'd0;

  always #2 clk = ~clk;   // 250 MHz

  uart_tx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .q_clear(q_clear), .word_len(word_len), .parity_mode(parity_mode),
    .stop_ext(stop_ext), .brk(brk), .cts(cts), .flow_en(flow_en),
    .txd(txd), .full(full), .empty(empty), .count(count)
  );

  // tick every fourth clock, counted after it has been consumed
  always @(negedge clk) begin
    if (tick16) tick_cnt <= tick_cnt + 1;
    tick16 <= (ph == 2'd2);
    ph <= ph + 2'd1;
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", total + 1, fails);
      $finish;
    end
  end

  // {word_len, parity_mode, stop_ext, data, frame ticks}
  localparam logic [21:0] VEC [9] = '{
    {2'd3, 3'b000, 1'b0, 8'hA5, 8'd160},
    {2'd3, 3'b001, 1'b0, 8'h5A, 8'd176},
    {2'd2, 3'b011, 1'b1, 8'h13, 8'd176},
    {2'd0, 3'b000, 1'b1, 8'h1F, 8'd120},
    {2'd3, 3'b011, 1'b1, 8'h81, 8'd176},
    {2'd1, 3'b101, 1'b0, 8'hFF, 8'd144},
    {2'd0, 3'b111, 1'b1, 8'h0A, 8'd144},
    {2'd1, 3'b010, 1'b1, 8'h2C, 8'd144},
    {2'd0, 3'b001, 1'b0, 8'h07, 8'd128}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic at_tick(input int t);
    while (tick_cnt < t) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic find_start(input int limit, output int s, output bit found);
    int stop_at;
    stop_at = tick_cnt + limit;
    found = 1'b0;
    s = 0;
    while (!found && tick_cnt < stop_at) begin
      @(negedge clk);
      if (txd == 1'b0) begin
        found = 1'b1;
        s = tick_cnt;
      end
    end
  endtask

  task automatic stays_high(input int n, output bit ok);
    int stop_at;
    stop_at = tick_cnt + n;
    ok = 1'b1;
    while (tick_cnt < stop_at) begin
      @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
    end
  endtask

  function automatic logic exp_parity(input logic [2:0] m, input logic [7:0] d);
    case (m[2:1])
      2'b00:   return ~(^d);
      2'b01:   return ^d;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // samples start, data and parity of a frame that began at tick s
  task automatic decode(input int s, input int nb, input bit pe, output logic st,
                        output logic [7:0] dat, output logic par);
    dat = 8'h00;
    at_tick(s + 8);
    st = txd;
    for (int i = 0; i < nb; i++) begin
      at_tick(s + 16 * (i + 1) + 8);
      dat[i] = txd;
    end
    par = 1'b0;
    if (pe) begin
      at_tick(s + 16 * (nb + 1) + 8);
      par = txd;
    end
  endtask

  initial begin
    int s;
    bit found, ok;
    logic st, par;
    logic [7:0] dat, want;

    repeat (4) @(negedge clk);
    // R1 reset state while reset is held
    check(txd == 1'b1, "R1 txd in reset", int'(txd), 1);
    check(empty == 1'b1 && full == 1'b0, "R1 flags in reset", int'({empty, full}), 2);
    check(count == 5'd0, "R1 count in reset", int'(count), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    stays_high(20, ok);
    check(ok, "R1 idle line high", int'(ok), 1);

    // table of formats
    for (int v = 0; v < 9; v++) begin
      int nb, len;
      bit pe;
      word_len    = VEC[v][21:20];
      parity_mode = VEC[v][19:17];
      stop_ext    = VEC[v][16];
      nb  = int'(VEC[v][21:20]) + 5;
      pe  = VEC[v][17];
      len = int'(VEC[v][7:0]);
      want = VEC[v][15:8] & ((8'h01 << nb) - 8'h01);
      push(VEC[v][15:8]);
      push(8'h00);
      find_start(100, s, found);
      check(found, $sformatf("R2 vec%0d frame started", v), int'(found), 1);
      decode(s, nb, pe, st, dat, par);
      check(st == 1'b0, $sformatf("R2 vec%0d start bit", v), int'(st), 0);
      check(dat == want, $sformatf("R2 vec%0d data bits", v), int'(dat), int'(want));
      if (pe)
        check(par == exp_parity(VEC[v][19:17], want), $sformatf("R3 vec%0d parity", v),
              int'(par), int'(exp_parity(VEC[v][19:17], want)));
      at_tick(s + len - 4);
      check(txd == 1'b1, $sformatf("R4 vec%0d stop high before end", v), int'(txd), 1);
      at_tick(s + len + 4);
      check(txd == 1'b0, $sformatf("R9 vec%0d next start on time", v), int'(txd), 0);
      at_tick(s + 2 * len + 20);
    end

    // queue capacity, dropped writes and clear
    word_len = 2'd3; parity_mode = 3'b000; stop_ext = 1'b0;
    flow_en = 1'b1; cts = 1'b0;
    for (int i = 0; i < 16; i++) push(8'(i));
    check(full == 1'b1 && count == 5'd16, "R5 queue full at 16", int'(count), 16);
    push(8'hEE);
    check(count == 5'd16, "R5 write to full dropped", int'(count), 16);
    @(negedge clk);
    q_clear = 1'b1; wr_en = 1'b1; wr_data = 8'h33;
    @(negedge clk);
    q_clear = 1'b0; wr_en = 1'b0;
    check(count == 5'd0 && empty == 1'b1, "R6 clear wins over write", int'(count), 0);
    cts = 1'b1;
    stays_high(60, ok);
    check(ok, "R6 nothing left to send after clear", int'(ok), 1);

    // clear-to-send holds a character back
    cts = 1'b0;
    push(8'h96);
    stays_high(100, ok);
    check(ok && count == 5'd1, "R7 held while cts low", int'(count), 1);
    cts = 1'b1;
    find_start(20, s, found);
    decode(s, 8, 1'b0, st, dat, par);
    check(found && dat == 8'h96, "R7 sent after cts rises", int'(dat), 'h96);
    at_tick(s + 200);

    // cts falls mid-frame: frame completes, next stays queued
    push(8'h55);
    push(8'h00);
    find_start(20, s, found);
    at_tick(s + 20);
    cts = 1'b0;
    decode(s, 8, 1'b0, st, dat, par);
    check(dat == 8'h55, "R7 frame completes after cts falls", int'(dat), 'h55);
    at_tick(s + 156);
    check(txd == 1'b1, "R7 stop bit sent", int'(txd), 1);
    at_tick(s + 164);
    check(txd == 1'b1 && count == 5'd1, "R7 no new start while cts low", int'(count), 1);
    flow_en = 1'b0;
    find_start(20, s, found);
    check(found, "R7 flow control off ignores cts", int'(found), 1);
    at_tick(s + 200);
    flow_en = 1'b1; cts = 1'b1;

    // break
    @(negedge clk);
    brk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(txd == 1'b0, "R8 break drives line low", int'(txd), 0);
    push(8'hC3);
    at_tick(tick_cnt + 100);
    check(txd == 1'b0 && count == 5'd1, "R8 no start during break", int'(count), 1);
    brk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(txd == 1'b1, "R8 line high after break", int'(txd), 1);
    find_start(20, s, found);
    decode(s, 8, 1'b0, st, dat, par);
    check(found && dat == 8'hC3, "R8 queued character sent after break", int'(dat), 'hC3);
    at_tick(s + 200);
    check(empty == 1'b1 && txd == 1'b1, "R1 idle after traffic", int'({empty, txd}), 3);

    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule